// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the received Ethernet byte stream and asks for a system wake-up when a frame carries the wake signature for this station. The signature is a run of six 0xFF sync bytes. Directly after the run come sixteen unbroken copies of the station's 48-bit node address. The signature may start at any byte offset in the frame. Header bytes and arbitrary payload can come before it, and arbitrary bytes can follow it before the frame ends.

Bytes arrive one per cycle while `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last byte. `rx_good` is sampled together with the last byte and reports whether the frame's CRC check passed. The block issues no wake until that CRC verdict arrives. When it does issue a wake, it is a single-cycle pulse in the cycle after the last byte is accepted.

Top module: `mpkt_wake_detect`

## Requirements
- R1: After reset `wake_pulse` is low and the matcher is hunting for a sync run.
- R2: A frame that holds six 0xFF bytes, followed by 16 copies of `node_addr` and ends good produces `wake_pulse` high for exactly one cycle. Each copy is sent as bits [47:40] first and bits [7:0] last. The pulse comes in the cycle after the byte carrying `rx_eof` is accepted. Copies in any other byte order, or of a different address, do not wake.
- R3: The signature is found at any offset in the frame, including offset 0, with arbitrary non-0xFF bytes before it and after it.
- R4: A sync run of only five 0xFF bytes followed by the address copies does not wake.
- R5: A sync run longer than six 0xFF bytes still qualifies. The address copies may follow the last 0xFF of the run.
- R6: If an address byte mismatches and that byte is 0xFF, it counts as the first byte of a new sync run. Five further 0xFF bytes followed by 16 copies then wake.
- R7: An address byte that mismatches and is not 0xFF discards the partial match. Any later wake needs a new run of six 0xFF bytes.
- R8: A frame whose `rx_good` is low with `rx_eof` never produces a wake pulse.
- R9: While `wake_en` is low no wake is produced. Dropping `wake_en` for one cycle in mid-signature discards the partial match.
- R10: A frame that ends mid-signature does not wake. A byte with `rx_sof` clears all match state, so a partial signature never carries into the next frame.
- R11: A signature whose last address byte is also the frame's last byte (with `rx_eof`) wakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_en | input | 1 | Enables signature matching and wake issue |
| node_addr | input | 48 | Station address; bits [47:40] are expected first on the wire |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_good | input | 1 | CRC verdict, qualified by `rx_eof` |
| rx_data | input | 8 | Received byte |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
Two functions can fall on the same cycle. Completion of the signature can coincide with the end-of-frame commit. A mismatch of an address byte can coincide with the start of a new sync run. The bench provokes the first case with a frame whose final address byte carries `rx_eof`, and judges it by a pulse exactly one cycle later. It provokes the second case by placing a 0xFF exactly where an address byte is due, followed by only five more 0xFF bytes. A wake there proves the failing byte was reused as the first sync byte. A control frame with a non-0xFF breaker and the same five 0xFF bytes must stay silent.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  typedef enum logic [1:0] {
    PH_HUNT  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_FOUND = 2'd2
  } mpw_phase_e;

  function automatic logic is_sync_byte(input logic [7:0] b);
    return b == 8'hFF;
  endfunction

  // bit offset of the address byte expected at signature position idx
  function automatic int addr_lane(input int idx, input int nbytes);
    return (nbytes - 1 - (idx % nbytes)) * 8;
  endfunction

endpackage

// File: rtl/mpw_byte_compare.sv
module mpw_byte_compare #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 7
) (
  input  logic [ADDR_BYTES*8-1:0] node_addr,
  input  logic [7:0]              rx_data,
  input  logic [IDX_W-1:0]        pos,
  output logic                    is_ff,
  output logic                    addr_ok
);
  import mpw_pkg::*;

  logic [7:0] expected;

  always_comb begin
    expected = node_addr[addr_lane(int'(pos), ADDR_BYTES) +: 8];
    is_ff    = is_sync_byte(rx_data);
    addr_ok  = (rx_data == expected);
  end

endmodule

// File: rtl/mpw_sig_fsm.sv
module mpw_sig_fsm #(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wake_en,
  input  logic                                      rx_valid,
  input  logic                                      rx_sof,
  input  logic                                      is_ff,
  input  logic                                      addr_ok,
  output logic [$clog2(ADDR_BYTES*COPIES)-1:0]      pos,
  output logic                                      found_next
);
  import mpw_pkg::*;

  localparam int SIG_LEN = ADDR_BYTES * COPIES;
  localparam int IDX_W   = $clog2(SIG_LEN);
  localparam int RUN_W   = $clog2(SYNC_LEN + 1);

  mpw_phase_e       phase_q, phase_d, ph_eff;
  logic [RUN_W-1:0] run_q, run_d, run_eff;
  logic [IDX_W-1:0] idx_q, idx_d, idx_eff;

  // named internal events for the checks below
  logic ev_sync, ev_done, ev_resync, ev_drop, ev_hold;
  logic frame_start;

  assign frame_start = rx_valid & rx_sof;

  // a start-of-frame byte is processed against a cleared state
  always_comb begin
    ph_eff  = frame_start ? PH_HUNT : phase_q;
    run_eff = frame_start ? '0 : run_q;
    idx_eff = frame_start ? '0 : idx_q;
  end

  assign pos = idx_eff;

  always_comb begin
    phase_d   = ph_eff;
    run_d     = run_eff;
    idx_d     = idx_eff;
    ev_sync   = 1'b0;
    ev_done   = 1'b0;
    ev_resync = 1'b0;
    ev_drop   = 1'b0;
    ev_hold   = 1'b0;
    if (!wake_en) begin
      phase_d = PH_HUNT;
      run_d   = '0;
      idx_d   = '0;
    end else if (rx_valid) begin
      case (ph_eff)
        PH_HUNT: begin
          if (is_ff) begin
            if (run_eff == RUN_W'(SYNC_LEN - 1)) begin
              phase_d = PH_ADDR;
              run_d   = '0;
              idx_d   = '0;
              ev_sync = 1'b1;
            end else begin
              run_d = run_eff + 1'b1;
            end
          end else begin
            run_d = '0;
          end
        end
        PH_ADDR: begin
          if (addr_ok) begin
            if (idx_eff == IDX_W'(SIG_LEN - 1)) begin
              phase_d = PH_FOUND;
              ev_done = 1'b1;
            end else begin
              idx_d = idx_eff + 1'b1;
            end
          end else if (is_ff && idx_eff == '0) begin
            ev_hold = 1'b1;            // longer sync run, still aligned
          end else if (is_ff) begin
            phase_d   = PH_HUNT;
            run_d     = RUN_W'(1);
            idx_d     = '0;
            ev_resync = 1'b1;
          end else begin
            phase_d = PH_HUNT;
            run_d   = '0;
            idx_d   = '0;
            ev_drop = 1'b1;
          end
        end
        PH_FOUND: ;
        default: phase_d = PH_HUNT;
      endcase
    end
  end

  assign found_next = (phase_d == PH_FOUND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HUNT;
      run_q   <= '0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      run_q   <= run_d;
      idx_q   <= idx_d;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |-> (int'(idx_q) < SIG_LEN));                        // R2
  AST_ADDR_AFTER_FF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_ADDR) |-> $past(is_ff));                               // R4
  AST_RESYNC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resync |=> (phase_q == PH_HUNT && run_q == RUN_W'(1)));                 // R6
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (phase_q == PH_HUNT && run_q == '0));                          // R7
  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_en |=> (phase_q == PH_HUNT && run_q == '0 && idx_q == '0));          // R9
  AST_SOF_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && wake_en && !is_ff) |=> (phase_q == PH_HUNT && run_q == '0)); // R10
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> (phase_q == PH_ADDR && idx_q == '0));                          // R5
  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_sync, ev_done, ev_resync, ev_drop, ev_hold}) <= 1);         // R2

endmodule

// File: rtl/mpw_wake_commit.sv
module mpw_wake_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic frame_ok,
  input  logic wake_en,
  input  logic found_next,
  output logic wake_pulse
);

  logic commit;

  assign commit = frame_end & frame_ok & wake_en & found_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_pulse <= 1'b0;
    else        wake_pulse <= commit;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);                                               // R2
  AST_NO_WAKE_BAD_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> !wake_pulse);                                 // R8
  AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_en |=> !wake_pulse);                                                 // R9
  AST_WAKE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(frame_end));                                          // R2

endmodule

// File: rtl/mpkt_wake_detect.sv
module mpkt_wake_detect #(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wake_en,
  input  logic [ADDR_BYTES*8-1:0] node_addr,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic                    rx_good,
  input  logic [7:0]              rx_data,
  output logic                    wake_pulse
);

  localparam int SIG_LEN = ADDR_BYTES * COPIES;
  localparam int IDX_W   = $clog2(SIG_LEN);

  logic [IDX_W-1:0] pos;
  logic             is_ff;
  logic             addr_ok;
  logic             found_next;

  mpw_byte_compare #(
    .ADDR_BYTES (ADDR_BYTES),
    .IDX_W      (IDX_W)
  ) i_cmp (
    .node_addr (node_addr),
    .rx_data   (rx_data),
    .pos       (pos),
    .is_ff     (is_ff),
    .addr_ok   (addr_ok)
  );

  mpw_sig_fsm #(
    .SYNC_LEN   (SYNC_LEN),
    .ADDR_BYTES (ADDR_BYTES),
    .COPIES     (COPIES)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_en    (wake_en),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .is_ff      (is_ff),
    .addr_ok    (addr_ok),
    .pos        (pos),
    .found_next (found_next)
  );

  mpw_wake_commit i_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (rx_valid & rx_eof),
    .frame_ok   (rx_good),
    .wake_en    (wake_en),
    .found_next (found_next),
    .wake_pulse (wake_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wake_pulse);                                             // R1

endmodule

// File: tb/test_mpkt_wake_detect.sv
module test_mpkt_wake_detect;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_en = 1'b0;
  logic [47:0] node_addr = 48'h11_22_33_44_55_66;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        wake_pulse;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] fq[$];

  always #4 clk = ~clk;   // 125 MHz

  mpkt_wake_detect i_mpkt_wake_detect (
    .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .node_addr(node_addr),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
    .rx_data(rx_data), .wake_pulse(wake_pulse)
  );

  typedef struct packed {
    logic [7:0] pre;
    logic [7:0] ffn;
    logic [7:0] cps;
    logic [7:0] brk;    // 255 = no corrupted address byte
    logic [7:0] post;
    logic       good;
    logic       en;
    logic       expw;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd12, 8'd6, 8'd16, 8'd255, 8'd4,  1'b1, 1'b1, 1'b1, 4'd2},   // R2 basic
    '{8'd20, 8'd6, 8'd16, 8'd255, 8'd0,  1'b1, 1'b1, 1'b1, 4'd11},  // R11 ends on last addr byte
    '{8'd12, 8'd5, 8'd16, 8'd255, 8'd4,  1'b1, 1'b1, 1'b0, 4'd4},   // R4 short sync
    '{8'd12, 8'd9, 8'd16, 8'd255, 8'd4,  1'b1, 1'b1, 1'b1, 4'd5},   // R5 long sync
    '{8'd12, 8'd6, 8'd16, 8'd40,  8'd4,  1'b1, 1'b1, 1'b0, 4'd7},   // R7 broken copy
    '{8'd12, 8'd6, 8'd16, 8'd255, 8'd4,  1'b0, 1'b1, 1'b0, 4'd8},   // R8 bad CRC
    '{8'd12, 8'd6, 8'd16, 8'd255, 8'd4,  1'b1, 1'b0, 1'b0, 4'd9},   // R9 disabled
    '{8'd33, 8'd6, 8'd16, 8'd255, 8'd30, 1'b1, 1'b1, 1'b1, 4'd3},   // R3 deep offset
    '{8'd12, 8'd6, 8'd10, 8'd255, 8'd0,  1'b1, 1'b1, 1'b0, 4'd10},  // R10 ends mid-signature
    '{8'd0,  8'd6, 8'd16, 8'd255, 8'd0,  1'b1, 1'b1, 1'b1, 4'd3}    // R3 offset zero
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(input int k);
    return node_addr[(5 - k) * 8 +: 8];
  endfunction

  task automatic put_fill(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) fq.push_back(base + 8'(i));
  endtask

  task automatic put_ff(input int n);
    for (int i = 0; i < n; i++) fq.push_back(8'hFF);
  endtask

  task automatic put_addr(input int copies, input int brk, input bit rev);
    for (int c = 0; c < copies; c++)
      for (int k = 0; k < 6; k++)
        fq.push_back((c * 6 + k == brk) ? 8'h5A : abyte(rev ? 5 - k : k));
  endtask

  // plays the queued bytes as one frame; hole_at inserts an idle cycle with enable low
  task automatic play(input logic good, input logic en, input int hole_at, input bit with_eof,
                      output logic got, output logic after, output bit early);
    early = 1'b0;
    for (int i = 0; i < fq.size(); i++) begin
      @(negedge clk);
      if (wake_pulse) early = 1'b1;
      if (i == hole_at) begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; wake_en = 1'b0;
        @(negedge clk);
      end
      wake_en  = en;
      rx_valid = 1'b1;
      rx_data  = fq[i];
      rx_sof   = (i == 0);
      rx_eof   = with_eof && (i == fq.size() - 1);
      rx_good  = good;
    end
    @(negedge clk);
    got = wake_pulse;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
    @(negedge clk);
    after = wake_pulse;
    fq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic got, after;
    bit   early;

    repeat (3) @(negedge clk);
    chk(wake_pulse == 1'b0, "R1 during reset", int'(wake_pulse), 0);
    rst_n = 1'b1;
    wake_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(wake_pulse == 1'b0, "R1 after reset", int'(wake_pulse), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      put_fill(VECS[v].pre, 8'h10);
      put_ff(VECS[v].ffn);
      put_addr(VECS[v].cps, VECS[v].brk, 1'b0);
      put_fill(VECS[v].post, 8'h30);
      play(VECS[v].good, VECS[v].en, -1, 1'b1, got, after, early);
      chk(got == VECS[v].expw, $sformatf("R%0d vector %0d wake", VECS[v].req, v),
          int'(got), int'(VECS[v].expw));
      chk(after == 1'b0, $sformatf("R2 vector %0d single pulse", v), int'(after), 0);
      chk(early == 1'b0, $sformatf("R2 vector %0d no early pulse", v), int'(early), 0);
    end
    wake_en = 1'b1;

    // R6: a 0xFF where an address byte is due starts a new run
    put_fill(12, 8'h10); put_ff(6);
    for (int k = 0; k < 3; k++) fq.push_back(abyte(k));
    put_ff(6); put_addr(16, -1, 1'b0); put_fill(2, 8'h30);
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b1, "R6 overlapping resync wakes", int'(got), 1);

    // R7: non-0xFF breaker, then only five 0xFF, must not wake
    put_fill(12, 8'h10); put_ff(6);
    for (int k = 0; k < 3; k++) fq.push_back(abyte(k));
    fq.push_back(8'h5A); put_ff(5); put_addr(16, -1, 1'b0);
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b0, "R7 drop then short run", int'(got), 0);

    // R10: partial signature abandoned without end, next frame continues it
    put_fill(12, 8'h10); put_ff(6); put_addr(8, -1, 1'b0);
    play(1'b1, 1'b1, -1, 1'b0, got, after, early);
    put_addr(8, -1, 1'b0); put_fill(2, 8'h30);
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b0, "R10 no carry across start-of-frame", int'(got), 0);
    put_fill(12, 8'h10); put_ff(6); put_addr(16, -1, 1'b0);
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b1, "R10 clean frame afterwards wakes", int'(got), 1);

    // R9: enable drops for one cycle in the middle of the address copies
    put_fill(12, 8'h10); put_ff(6); put_addr(16, -1, 1'b0); put_fill(2, 8'h30);
    play(1'b1, 1'b1, 60, 1'b1, got, after, early);
    chk(got == 1'b0, "R9 enable dip discards match", int'(got), 0);

    // R2: byte order and a different address
    put_fill(12, 8'h10); put_ff(6); put_addr(16, -1, 1'b1);
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b0, "R2 reversed byte order rejected", int'(got), 0);
    put_fill(12, 8'h10); put_ff(6); put_addr(16, -1, 1'b0);
    node_addr = 48'hA1_B2_C3_D4_E5_F6;
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b0, "R2 other station address rejected", int'(got), 0);
    put_fill(12, 8'h10); put_ff(6); put_addr(16, -1, 1'b0);
    play(1'b1, 1'b1, -1, 1'b1, got, after, early);
    chk(got == 1'b1, "R2 new address wakes", int'(got), 1);
    chk(after == 1'b0, "R2 new address single pulse", int'(after), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule